// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a synchronous 1024-word by 8-bit memory with two independent ports, called left and right. Each port has an enable, a write select, an output enable, an address and write data. Either port can reach any word in any cycle. When both enabled ports present the same address, the block grants the word to one of them and drives an active-low busy flag toward the other. A write from the losing port is dropped, and its read data stays frozen.

The winner is the port whose access was already in progress, meaning it was enabled on the same address in the previous cycle. When both ports arrive in the same cycle, the left port wins. A build-time option turns the block into a slave. In that mode it does no arbitration of its own. Instead it takes the busy flags as inputs from a master instance, so that several devices can sit side by side to form a wider word.

Reads are registered. The data appears one cycle after the address, and a separate valid flag is gated by the output enable.

Top module: `dual_port_arbiter_ram`

## Requirements
- R1: Data written through either port at any address is returned by a later read of that address through either port. Read data appears on the rising edge that follows the cycle in which the read was presented.
- R2: After reset, both read-data outputs are 0 and both valid outputs are 0. A valid output is 1 in the cycle after a read (enable 1, write select 0) made with output enable 1. It is 0 after a read with output enable 0, and 0 after a cycle in which the port is disabled or writing.
- R3: In master mode, busy (active low, 0 = blocked) goes low on exactly one port in the same cycle that both ports are enabled on equal addresses. Busy is high on both ports in any cycle without such a match, including the cycle in which one port's address moves away or its enable drops.
- R4: On a match, a port that was already enabled on that address in the previous cycle wins against a port that just arrived. The winner stays the same for as long as the match persists.
- R5: When neither port holds the address from the previous cycle (both arrive together), the left port wins and the right port gets busy low.
- R6: A write presented while the port's busy is low is discarded and never applied later, and the winner's access is unaffected.
- R7: A port that reads while it has busy low returns the word as it stood before that edge. It keeps that read data unchanged until it changes its address, enable or write select, even after busy clears. Its next read after such a change returns the current contents.
- R8: Both ports may read the same word in the same cycle, and both receive its contents.
- R9: In slave mode both busy outputs stay high whatever the addresses. A busy input held low (0 = blocked) discards that port's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable, gates l_valid |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_valid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left blocked flag, active low (master mode) |
| l_busy_in_n | input | 1 | Left blocked flag from a master, active low (slave mode) |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable, gates r_valid |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_valid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right blocked flag, active low (master mode) |
| r_busy_in_n | input | 1 | Right blocked flag from a master, active low (slave mode) |

## Verification
A wrong owner held in the arbiter shows up at once on the busy pins, in the very cycle of the match. It also shows up one cycle later as a word that carries the loser's data instead of the winner's. A freeze flag that fails to set or to clear appears on the losing port's read data on the next edge: that is either a new value while the access is unchanged, or a stale value after the access changed. The bench reads every contested word back through a quiet port, so a write that leaked past the block surfaces within two cycles.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
endpackage

// File: rtl/dpa_store.sv
module dpa_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wd,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wd,
   output logic [DATA_W-1:0] l_q,
   output logic [DATA_W-1:0] r_q
);
   logic [DATA_W-1:0] mem [DEPTH];

   // right first, so the left port wins if an outside master lets both through
   always_ff @(posedge clk) begin
      if (r_we) mem[r_addr] <= r_wd;
      if (l_we) mem[l_addr] <= l_wd;
   end

   assign l_q = mem[l_addr];
   assign r_q = mem[r_addr];
endmodule

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic              oe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              blocked_i,
   input  logic [DATA_W-1:0] mem_q_i,
   output logic              held_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              valid_o
);
   logic              prev_en, prev_wr, frozen_q, valid_q;
   logic [ADDR_W-1:0] prev_addr;
   logic [DATA_W-1:0] rdata_q;
   logic              rd, chg, keep;

   assign rd     = en_i && !wr_i;
   assign chg    = (en_i != prev_en) || (wr_i != prev_wr) || (addr_i != prev_addr);
   assign keep   = frozen_q && !chg;
   assign held_o = en_i && prev_en && (addr_i == prev_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en   <= 1'b0;
         prev_wr   <= 1'b0;
         prev_addr <= '0;
         frozen_q  <= 1'b0;
         rdata_q   <= '0;
         valid_q   <= 1'b0;
      end else begin
         prev_en   <= en_i;
         prev_wr   <= wr_i;
         prev_addr <= addr_i;
         frozen_q  <= rd && (blocked_i || keep);
         valid_q   <= rd && oe_i;
         if (rd && !keep) rdata_q <= mem_q_i;
      end
   end

   assign rdata_o = rdata_q;
   assign valid_o = valid_q;

   // R7: a frozen read with an unchanged access keeps its data
   assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_q && !chg) |=> $stable(rdata_o));
   // R2: output enable low gives no valid in the next cycle
   assert_oe_gates_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_i || !en_i) |=> !valid_o);
endmodule

// File: rtl/dpa_collide.sv
module dpa_collide
   import dpa_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_held,
   input  logic              r_held,
   output logic              l_lose_o,
   output logic              r_lose_o
);
   logic  match, match_q;
   side_e win, own_q;

   assign match = l_en && r_en && (l_addr == r_addr);

   always_comb begin
      if (match_q)              win = own_q;
      else if (r_held && !l_held) win = SIDE_R;
      else                      win = SIDE_L;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         own_q   <= SIDE_L;
      end else begin
         match_q <= match;
         if (match) own_q <= win;
      end
   end

   assign l_lose_o = match && (win == SIDE_R);
   assign r_lose_o = match && (win == SIDE_L);

   // R3: exactly one loser on a match
   assert_one_loser_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (l_en && r_en && l_addr == r_addr) |-> $countones({l_lose_o, r_lose_o}) == 1);
   // R3: nobody blocked without a match
   assert_no_false_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en || !r_en || l_addr != r_addr) |-> !l_lose_o && !r_lose_o);
   // R4: a persisting match keeps its winner
   assert_owner_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match && match_q) |-> $stable(l_lose_o));
   // R4: the holder beats a newcomer
   assert_holder_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !match_q && l_held && !r_held) |-> r_lose_o);
endmodule

// File: rtl/dual_port_arbiter_ram.sv
module dual_port_arbiter_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   parameter bit SLAVE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_valid,
   output logic              l_busy_n,
   input  logic              l_busy_in_n,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_valid,
   output logic              r_busy_n,
   input  logic              r_busy_in_n
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("dual_port_arbiter_ram: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dual_port_arbiter_ram: DATA_W must be positive");
   end

   logic              l_blk, r_blk, l_held, r_held, l_we, r_we;
   logic [DATA_W-1:0] l_q, r_q;

   if (SLAVE) begin : g_slave
      logic unused_held;
      assign unused_held = l_held ^ r_held;
      assign l_blk    = !l_busy_in_n;
      assign r_blk    = !r_busy_in_n;
      assign l_busy_n = 1'b1;
      assign r_busy_n = 1'b1;
      // R9: an external block stops the write
      assert_slave_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !l_busy_in_n |-> !l_we);
   end else begin : g_master
      logic unused_busy_in;
      logic l_lose, r_lose;
      assign unused_busy_in = l_busy_in_n ^ r_busy_in_n;
      dpa_collide #(.ADDR_W(ADDR_W)) i_collide (
         .clk(clk), .rst_n(rst_n), .l_en(l_en), .r_en(r_en),
         .l_addr(l_addr), .r_addr(r_addr), .l_held(l_held), .r_held(r_held),
         .l_lose_o(l_lose), .r_lose_o(r_lose));
      assign l_blk    = l_lose;
      assign r_blk    = r_lose;
      assign l_busy_n = !l_lose;
      assign r_busy_n = !r_lose;
      // R6: two writes never land on one word
      assert_single_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (l_we && r_we) |-> l_addr != r_addr);
      // R6: a busy port never writes
      assert_busy_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!l_busy_n || !r_busy_n) |-> !(l_we && !l_busy_n) && !(r_we && !r_busy_n));
   end

   assign l_we = l_en && l_wr && !l_blk;
   assign r_we = r_en && r_wr && !r_blk;

   dpa_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
      .clk(clk), .l_we(l_we), .l_addr(l_addr), .l_wd(l_wdata),
      .r_we(r_we), .r_addr(r_addr), .r_wd(r_wdata), .l_q(l_q), .r_q(r_q));

   dpa_port_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_left (
      .clk(clk), .rst_n(rst_n), .en_i(l_en), .wr_i(l_wr), .oe_i(l_oe),
      .addr_i(l_addr), .blocked_i(l_blk), .mem_q_i(l_q), .held_o(l_held),
      .rdata_o(l_rdata), .valid_o(l_valid));

   dpa_port_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_right (
      .clk(clk), .rst_n(rst_n), .en_i(r_en), .wr_i(r_wr), .oe_i(r_oe),
      .addr_i(r_addr), .blocked_i(r_blk), .mem_q_i(r_q), .held_o(r_held),
      .rdata_o(r_rdata), .valid_o(r_valid));
endmodule

// File: tb/test_dual_port_arbiter_ram.sv
module test_dual_port_arbiter_ram;
   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       ml_en, ml_wr, ml_oe, mr_en, mr_wr, mr_oe;
   logic [9:0] ml_addr, mr_addr;
   logic [7:0] ml_wd, mr_wd, ml_rd, mr_rd;
   logic       ml_v, mr_v, ml_bn, mr_bn;
   logic       sl_en, sl_wr, sl_oe, sr_en, sr_wr, sr_oe;
   logic [9:0] sl_addr, sr_addr;
   logic [7:0] sl_wd, sr_wd, sl_rd, sr_rd;
   logic       sl_v, sr_v, sl_bn, sr_bn, sl_bin, sr_bin;

   dual_port_arbiter_ram i_dual_port_arbiter_ram (
      .clk(clk), .rst_n(rst_n),
      .l_en(ml_en), .l_wr(ml_wr), .l_oe(ml_oe), .l_addr(ml_addr), .l_wdata(ml_wd),
      .l_rdata(ml_rd), .l_valid(ml_v), .l_busy_n(ml_bn), .l_busy_in_n(1'b1),
      .r_en(mr_en), .r_wr(mr_wr), .r_oe(mr_oe), .r_addr(mr_addr), .r_wdata(mr_wd),
      .r_rdata(mr_rd), .r_valid(mr_v), .r_busy_n(mr_bn), .r_busy_in_n(1'b1));

   dual_port_arbiter_ram #(.SLAVE(1'b1)) i_dual_port_arbiter_ram_slv (
      .clk(clk), .rst_n(rst_n),
      .l_en(sl_en), .l_wr(sl_wr), .l_oe(sl_oe), .l_addr(sl_addr), .l_wdata(sl_wd),
      .l_rdata(sl_rd), .l_valid(sl_v), .l_busy_n(sl_bn), .l_busy_in_n(sl_bin),
      .r_en(sr_en), .r_wr(sr_wr), .r_oe(sr_oe), .r_addr(sr_addr), .r_wdata(sr_wd),
      .r_rdata(sr_rd), .r_valid(sr_v), .r_busy_n(sr_bn), .r_busy_in_n(sr_bin));

   typedef struct {
      int         sel;
      logic [7:0] d;
      logic       v;
      int         due;
      string      tag;
   } exp_t;
   exp_t q[$];
   int   cyc = 0, checks = 0, errors = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // monitor: compares registered read results when they are due
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         logic [7:0] d;
         logic v;
         e = q.pop_front();
         case (e.sel)
            0: begin d = ml_rd; v = ml_v; end
            1: begin d = mr_rd; v = mr_v; end
            2: begin d = sl_rd; v = sl_v; end
            default: begin d = sr_rd; v = sr_v; end
         endcase
         check(d == e.d && v == e.v, e.tag, {v, d}, {e.v, e.d});
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic setp(input int sel, input bit en, input bit wr, input bit oe,
                       input logic [9:0] a, input logic [7:0] d);
      case (sel)
         0: begin ml_en = en; ml_wr = wr; ml_oe = oe; ml_addr = a; ml_wd = d; end
         1: begin mr_en = en; mr_wr = wr; mr_oe = oe; mr_addr = a; mr_wd = d; end
         2: begin sl_en = en; sl_wr = wr; sl_oe = oe; sl_addr = a; sl_wd = d; end
         default: begin sr_en = en; sr_wr = wr; sr_oe = oe; sr_addr = a; sr_wd = d; end
      endcase
   endtask

   task automatic expect_rd(input int sel, input logic [7:0] d, input bit v, input string tag);
      exp_t e;
      e.sel = sel; e.d = d; e.v = v; e.due = cyc + 1; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic chk_busy(input bit slv, input bit el, input bit er, input string tag);
      #1;
      if (slv) check(sl_bn == el && sr_bn == er, tag, {sl_bn, sr_bn}, {el, er});
      else     check(ml_bn == el && mr_bn == er, tag, {ml_bn, mr_bn}, {el, er});
   endtask

   task automatic all_off();
      for (int s = 0; s < 4; s++) setp(s, 0, 0, 0, 10'd0, 8'd0);
   endtask

   initial begin
      all_off();
      sl_bin = 1'b1; sr_bin = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(ml_rd == 0 && ml_v == 0 && mr_rd == 0 && mr_v == 0, "R2 reset", {ml_v, ml_rd}, 0);
      rst_n = 1'b1;
      #1;
      check(ml_bn && mr_bn, "R3 reset busy", {ml_bn, mr_bn}, 3);

      // distinct-address writes, then cross reads
      tick(); setp(0, 1, 1, 0, 10'd5, 8'hA5); setp(1, 1, 1, 0, 10'd700, 8'h3C);
      chk_busy(0, 1, 1, "R3 no match");
      tick(); setp(0, 1, 0, 1, 10'd700, 0); setp(1, 1, 0, 1, 10'd5, 0);
      expect_rd(0, 8'h3C, 1, "R1 left reads right data");
      expect_rd(1, 8'hA5, 1, "R1 right reads left data");
      tick(); setp(0, 1, 0, 0, 10'd5, 0); setp(1, 0, 0, 0, 10'd0, 0);
      expect_rd(0, 8'hA5, 0, "R2 oe low");
      expect_rd(1, 8'hA5, 0, "R2 disabled");

      // same-cycle arrival: left wins, right write discarded
      tick(); all_off();
      tick(); setp(0, 1, 1, 0, 10'd9, 8'h11); setp(1, 1, 1, 0, 10'd9, 8'h22);
      chk_busy(0, 1, 0, "R5 tie to left");
      tick(); setp(1, 1, 1, 0, 10'd9, 8'h33);
      chk_busy(0, 1, 0, "R4 winner kept");
      tick(); all_off();
      tick(); setp(0, 1, 0, 1, 10'd9, 0);
      expect_rd(0, 8'h11, 1, "R6 loser write dropped");

      // earlier holder wins against newcomer
      tick(); setp(0, 1, 1, 0, 10'd20, 8'h77);
      tick(); setp(0, 0, 0, 0, 0, 0); setp(1, 1, 0, 1, 10'd20, 0);
      expect_rd(1, 8'h77, 1, "R1 read 20");
      tick(); setp(0, 1, 1, 0, 10'd20, 8'h55);
      chk_busy(0, 0, 1, "R4 holder right wins");
      expect_rd(1, 8'h77, 1, "R6 winner unaffected");
      tick();
      chk_busy(0, 0, 1, "R4 persists");
      expect_rd(1, 8'h77, 1, "R6 blocked write absent");
      tick(); setp(0, 1, 1, 0, 10'd21, 8'h56);
      chk_busy(0, 1, 1, "R3 release on address move");
      expect_rd(1, 8'h77, 1, "R6 word 20 intact");
      tick(); setp(0, 1, 0, 1, 10'd20, 0);
      chk_busy(0, 0, 1, "R3 newcomer reader blocked");
      expect_rd(0, 8'h77, 1, "R8 left shared read");
      expect_rd(1, 8'h77, 1, "R8 right shared read");
      tick(); setp(0, 0, 0, 0, 0, 0);
      chk_busy(0, 1, 1, "R3 release on enable low");
      expect_rd(1, 8'h77, 1, "R8 right continues");
      tick(); setp(1, 1, 0, 1, 10'd21, 0);
      expect_rd(1, 8'h56, 1, "R1 read 21");

      // frozen loser read
      tick(); all_off();
      tick(); setp(0, 1, 1, 0, 10'd30, 8'h41);
      tick(); setp(0, 1, 1, 0, 10'd30, 8'h42); setp(1, 1, 0, 1, 10'd30, 0);
      chk_busy(0, 1, 0, "R4 writer holds");
      expect_rd(1, 8'h41, 1, "R7 loser sees old word");
      tick(); setp(0, 1, 1, 0, 10'd30, 8'h43);
      expect_rd(1, 8'h41, 1, "R7 frozen during writes");
      tick(); setp(0, 0, 0, 0, 0, 0);
      chk_busy(0, 1, 1, "R3 release");
      expect_rd(1, 8'h41, 1, "R7 frozen after busy clears");
      tick(); setp(1, 0, 0, 0, 10'd30, 0);
      expect_rd(1, 8'h41, 0, "R7 disabled keeps data");
      tick(); setp(1, 1, 0, 1, 10'd30, 0);
      expect_rd(1, 8'h43, 1, "R7 fresh after change");

      // slave mode
      tick(); all_off(); setp(2, 1, 1, 0, 10'd3, 8'h10);
      chk_busy(1, 1, 1, "R9 outputs idle");
      tick(); setp(2, 1, 1, 0, 10'd3, 8'h99); sl_bin = 1'b0; setp(3, 1, 0, 1, 10'd3, 0);
      chk_busy(1, 1, 1, "R9 no internal arbitration");
      expect_rd(3, 8'h10, 1, "R9 read during blocked write");
      tick(); setp(2, 0, 0, 0, 0, 0); sl_bin = 1'b1;
      expect_rd(3, 8'h10, 1, "R9 blocked write dropped");
      tick(); all_off();
      tick(); tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule